// File: doc/BRIEF.md
# Ethernet PHY Control Register with MII Isolation

This block holds the basic control word of a 10/100 Ethernet transceiver and turns its bits into effects on the media-independent interface (MII) pins. A management agent reads and writes the word through a plain register port. After reset, some fields take their values from strap pins. Five fields are implemented:

- a power-down field, which disables the line and LED drivers;
- an isolate field, which tri-states the MII and gates off transmit input;
- a self-clearing autonegotiation restart request;
- a manual duplex selection;
- a collision loopback test.

The register port keeps working while the MII is isolated.

The block has a two-stage reset synchronizer. Reset asserts at once and releases on a clock edge. On the first clock after reset releases, the strap pins are copied into the isolate and duplex fields. After that, the strap pins are not looked at again. A restart request produces a one-cycle kick toward the autonegotiation engine. The request bit stays set until that engine reports completion.

Top module: `phy_ctl_top`

## Requirements
- R1: The control word places power-down at bit 11, isolate at bit 10, restart at bit 9, duplex at bit 8 and collision test at bit 7. A write updates bits 11, 10, 8 and 7 on the next clock edge. All other bits (15:12 and 6:0) ignore writes and read as 0.
- R2: On the first clock after reset releases, the fields are set from the straps:
  - isolate is 1 exactly when the strapped PHY address is 00000;
  - duplex is 1 exactly when the autonegotiation strap is 0 and at least one of the two full-duplex straps is 1;
  - power-down, restart and collision test are 0.
- R3: Changes on the strap pins after that first clock have no effect on the register.
- R4: While isolate or power-down is 1:
  - `mii_oe` is 0;
  - every MII receive, status and clock output is driven 0;
  - `dp_txd`, `dp_tx_en` and `dp_tx_er` are 0, whatever arrives on the MII transmit inputs;
  - management reads and writes still work.
- R5: While power-down is 1, `line_tx_oe` and `led_oe` are 0. Reset clears power-down.
- R6: Writing 1 to bit 9 while `an_enable` is 1 sets the restart bit and pulses `an_kick` for exactly the one cycle after the write. The same write while `an_enable` is 0 is ignored.
- R7: The restart bit clears on the clock after `an_done` is 1. Writing 0 to bit 9 does not clear it. A new accepted request in the same cycle as `an_done` keeps the bit set.
- R8: `link_full_duplex` follows `an_fd_result` while `an_enable` is 1, and follows the duplex bit while `an_enable` is 0.
- R9: While not isolated, `mii_col` is the internal collision input ORed with (collision test AND `mii_tx_en`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mgmt_wr_en | input | 1 | Write strobe of the control word |
| mgmt_wr_data | input | 16 | Write data |
| mgmt_rd_data | output | 16 | Current control word |
| strap_phy_addr | input | 5 | Strapped PHY address |
| strap_an_en | input | 1 | Autonegotiation-enable strap |
| strap_fd100 | input | 1 | 100 Mb/s full-duplex strap |
| strap_fd10 | input | 1 | 10 Mb/s full-duplex strap |
| an_enable | input | 1 | Autonegotiation currently enabled |
| an_done | input | 1 | Autonegotiation completed |
| an_fd_result | input | 1 | Duplex result of autonegotiation |
| an_kick | output | 1 | One-cycle restart pulse |
| link_full_duplex | output | 1 | Duplex in effect on the link |
| mii_txd | input | 4 | MII transmit data |
| mii_tx_en | input | 1 | MII transmit enable |
| mii_tx_er | input | 1 | MII transmit error |
| dp_txd | output | 4 | Gated transmit data toward datapath |
| dp_tx_en | output | 1 | Gated transmit enable |
| dp_tx_er | output | 1 | Gated transmit error |
| core_tx_clk | input | 1 | Internal transmit clock |
| core_rx_clk | input | 1 | Internal receive clock |
| core_rxd | input | 4 | Internal receive data |
| core_rx_dv | input | 1 | Internal receive data valid |
| core_rx_er | input | 1 | Internal receive error |
| core_crs | input | 1 | Internal carrier sense |
| core_col | input | 1 | Internal collision |
| mii_tx_clk | output | 1 | MII transmit clock |
| mii_rx_clk | output | 1 | MII receive clock |
| mii_rxd | output | 4 | MII receive data |
| mii_rx_dv | output | 1 | MII receive data valid |
| mii_rx_er | output | 1 | MII receive error |
| mii_crs | output | 1 | MII carrier sense |
| mii_col | output | 1 | MII collision |
| mii_oe | output | 1 | Output enable of all MII outputs |
| line_tx_oe | output | 1 | Line transmitter enable |
| led_oe | output | 1 | LED driver enable |

## Verification
The register is driven through a sequence of writes that moves isolate, power-down and collision test independently. Transmit enable and the internal collision input are toggled around each write. This separates a collision that comes from loopback from one that comes from the line, and it shows that isolation blocks the loopback.

Restart is tried in several ways:
- with autonegotiation disabled;
- with a write of 0 while pending;
- with completion and a new request in the same cycle.

These cases separate set-priority from clear-priority. Several strap combinations are then applied through reset. They cover address zero versus non-zero and each full-duplex strap alone, and they check that strap changes after reset leave the register unchanged.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;
  localparam int CTL_W     = 16;
  localparam int BIT_PD    = 11;
  localparam int BIT_ISO   = 10;
  localparam int BIT_RSTAN = 9;
  localparam int BIT_DUP   = 8;
  localparam int BIT_COLT  = 7;

  typedef struct packed {
    logic pd;
    logic iso;
    logic rstan;
    logic dup;
    logic colt;
  } ctl_bits_t;
endpackage

// File: rtl/phy_rst_sync.sv
module phy_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/phy_ctl_regs.sv
module phy_ctl_regs
  import phy_ctl_pkg::*;
#(
  parameter int REG_W  = CTL_W,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              an_enable,
  input  logic              an_done,
  input  logic [ADDR_W-1:0] strap_addr,
  input  logic              strap_an,
  input  logic              strap_fd100,
  input  logic              strap_fd10,
  output ctl_bits_t         ctl_q,
  output logic              kick_q,
  output logic              boot_q,
  output logic [REG_W-1:0]  rd_data
);
  ctl_bits_t ctl_d;
  logic      kick_d;
  logic      boot_d;
  logic      strap_iso;
  logic      strap_dup;
  logic      restart_ok;

  // strap decode used only during the boot cycle
  always_comb begin
    strap_iso = (strap_addr == '0);
    strap_dup = !strap_an && (strap_fd100 || strap_fd10);
  end

  always_comb begin
    restart_ok = wr_en && wr_data[BIT_RSTAN] && an_enable;
    ctl_d  = ctl_q;
    kick_d = 1'b0;
    boot_d = 1'b0;
    if (boot_q) begin
      ctl_d.pd    = 1'b0;
      ctl_d.iso   = strap_iso;
      ctl_d.rstan = 1'b0;
      ctl_d.dup   = strap_dup;
      ctl_d.colt  = 1'b0;
    end else begin
      if (wr_en) begin
        ctl_d.pd   = wr_data[BIT_PD];
        ctl_d.iso  = wr_data[BIT_ISO];
        ctl_d.dup  = wr_data[BIT_DUP];
        ctl_d.colt = wr_data[BIT_COLT];
      end
      // accepted request wins over completion in the same cycle
      if (restart_ok)    ctl_d.rstan = 1'b1;
      else if (an_done)  ctl_d.rstan = 1'b0;
      kick_d = restart_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '{pd: 1'b0, iso: 1'b1, rstan: 1'b0, dup: 1'b0, colt: 1'b0};
      kick_q <= 1'b0;
      boot_q <= 1'b1;
    end else begin
      ctl_q  <= ctl_d;
      kick_q <= kick_d;
      boot_q <= boot_d;
    end
  end

  always_comb begin
    rd_data            = '0;
    rd_data[BIT_PD]    = ctl_q.pd;
    rd_data[BIT_ISO]   = ctl_q.iso;
    rd_data[BIT_RSTAN] = ctl_q.rstan;
    rd_data[BIT_DUP]   = ctl_q.dup;
    rd_data[BIT_COLT]  = ctl_q.colt;
  end
endmodule

// File: rtl/phy_mii_gate.sv
module phy_mii_gate
  import phy_ctl_pkg::*;
#(
  parameter int MII_W = 4
) (
  input  ctl_bits_t         ctl,
  input  logic [MII_W-1:0]  txd_in,
  input  logic              tx_en_in,
  input  logic              tx_er_in,
  input  logic              c_tx_clk,
  input  logic              c_rx_clk,
  input  logic [MII_W-1:0]  c_rxd,
  input  logic              c_rx_dv,
  input  logic              c_rx_er,
  input  logic              c_crs,
  input  logic              c_col,
  output logic [MII_W-1:0]  txd_out,
  output logic              tx_en_out,
  output logic              tx_er_out,
  output logic              o_tx_clk,
  output logic              o_rx_clk,
  output logic [MII_W-1:0]  o_rxd,
  output logic              o_rx_dv,
  output logic              o_rx_er,
  output logic              o_crs,
  output logic              o_col,
  output logic              o_oe,
  output logic              o_line_oe,
  output logic              o_led_oe
);
  logic cut;

  always_comb begin
    cut       = ctl.iso || ctl.pd;
    o_oe      = !cut;
    o_line_oe = !ctl.pd;
    o_led_oe  = !ctl.pd;

    txd_out   = cut ? '0   : txd_in;
    tx_en_out = cut ? 1'b0 : tx_en_in;
    tx_er_out = cut ? 1'b0 : tx_er_in;

    o_tx_clk  = cut ? 1'b0 : c_tx_clk;
    o_rx_clk  = cut ? 1'b0 : c_rx_clk;
    o_rxd     = cut ? '0   : c_rxd;
    o_rx_dv   = cut ? 1'b0 : c_rx_dv;
    o_rx_er   = cut ? 1'b0 : c_rx_er;
    o_crs     = cut ? 1'b0 : c_crs;
    // loopback uses the gated enable so isolation blocks it too
    o_col     = cut ? 1'b0 : (c_col || (ctl.colt && tx_en_out));
  end
endmodule

// File: rtl/phy_ctl_top.sv
module phy_ctl_top
  import phy_ctl_pkg::*;
#(
  parameter int REG_W       = CTL_W,
  parameter int ADDR_W      = 5,
  parameter int MII_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mgmt_wr_en,
  input  logic [REG_W-1:0]  mgmt_wr_data,
  output logic [REG_W-1:0]  mgmt_rd_data,
  input  logic [ADDR_W-1:0] strap_phy_addr,
  input  logic              strap_an_en,
  input  logic              strap_fd100,
  input  logic              strap_fd10,
  input  logic              an_enable,
  input  logic              an_done,
  input  logic              an_fd_result,
  output logic              an_kick,
  output logic              link_full_duplex,
  input  logic [MII_W-1:0]  mii_txd,
  input  logic              mii_tx_en,
  input  logic              mii_tx_er,
  output logic [MII_W-1:0]  dp_txd,
  output logic              dp_tx_en,
  output logic              dp_tx_er,
  input  logic              core_tx_clk,
  input  logic              core_rx_clk,
  input  logic [MII_W-1:0]  core_rxd,
  input  logic              core_rx_dv,
  input  logic              core_rx_er,
  input  logic              core_crs,
  input  logic              core_col,
  output logic              mii_tx_clk,
  output logic              mii_rx_clk,
  output logic [MII_W-1:0]  mii_rxd,
  output logic              mii_rx_dv,
  output logic              mii_rx_er,
  output logic              mii_crs,
  output logic              mii_col,
  output logic              mii_oe,
  output logic              line_tx_oe,
  output logic              led_oe
);
  logic      rst_s_n;
  ctl_bits_t ctl;
  logic      boot;

  phy_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  phy_ctl_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_s_n),
    .wr_en(mgmt_wr_en), .wr_data(mgmt_wr_data),
    .an_enable(an_enable), .an_done(an_done),
    .strap_addr(strap_phy_addr), .strap_an(strap_an_en),
    .strap_fd100(strap_fd100), .strap_fd10(strap_fd10),
    .ctl_q(ctl), .kick_q(an_kick), .boot_q(boot),
    .rd_data(mgmt_rd_data)
  );

  phy_mii_gate #(.MII_W(MII_W)) u_gate (
    .ctl(ctl),
    .txd_in(mii_txd), .tx_en_in(mii_tx_en), .tx_er_in(mii_tx_er),
    .c_tx_clk(core_tx_clk), .c_rx_clk(core_rx_clk), .c_rxd(core_rxd),
    .c_rx_dv(core_rx_dv), .c_rx_er(core_rx_er), .c_crs(core_crs),
    .c_col(core_col),
    .txd_out(dp_txd), .tx_en_out(dp_tx_en), .tx_er_out(dp_tx_er),
    .o_tx_clk(mii_tx_clk), .o_rx_clk(mii_rx_clk), .o_rxd(mii_rxd),
    .o_rx_dv(mii_rx_dv), .o_rx_er(mii_rx_er), .o_crs(mii_crs),
    .o_col(mii_col), .o_oe(mii_oe),
    .o_line_oe(line_tx_oe), .o_led_oe(led_oe)
  );

  always_comb begin
    link_full_duplex = an_enable ? an_fd_result : ctl.dup;
  end
endmodule

// File: rtl/phy_ctl_chk.sv
module phy_ctl_chk #(
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             boot,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             an_enable,
  input logic             an_done,
  input logic             an_fd_result,
  input logic             an_kick,
  input logic             link_fd,
  input logic             tx_en,
  input logic             dp_tx_en,
  input logic             mii_col,
  input logic             mii_oe,
  input logic             line_oe,
  input logic             led_oe
);
  p_iso_oe_r4: assert property (@(posedge clk) disable iff (!rst_n || boot)
    (rd_data[10] || rd_data[11]) |-> !mii_oe);
  p_iso_tx_r4: assert property (@(posedge clk) disable iff (!rst_n || boot)
    !mii_oe |-> !dp_tx_en);
  p_pd_off_r5: assert property (@(posedge clk) disable iff (!rst_n || boot)
    rd_data[11] |-> (!line_oe && !led_oe));
  p_kick_bit_r6: assert property (@(posedge clk) disable iff (!rst_n || boot)
    an_kick |-> rd_data[9]);
  p_kick_src_r6: assert property (@(posedge clk) disable iff (!rst_n || boot)
    (wr_en && wr_data[9] && an_enable) |=> an_kick);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n || boot)
    (rd_data[9] && an_done && !(wr_en && wr_data[9] && an_enable)) |=> !rd_data[9]);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n || boot)
    !wr_en |=> $stable({rd_data[11:10], rd_data[8:7]}));
  p_fd_sel_r8: assert property (@(posedge clk) disable iff (!rst_n || boot)
    link_fd == (an_enable ? an_fd_result : rd_data[8]));
  p_col_loop_r9: assert property (@(posedge clk) disable iff (!rst_n || boot)
    (mii_oe && rd_data[7] && tx_en) |-> mii_col);
endmodule

bind phy_ctl_top phy_ctl_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .boot(u_regs.boot_q),
  .wr_en(mgmt_wr_en), .wr_data(mgmt_wr_data), .rd_data(mgmt_rd_data),
  .an_enable(an_enable), .an_done(an_done), .an_fd_result(an_fd_result),
  .an_kick(an_kick), .link_fd(link_full_duplex), .tx_en(mii_tx_en),
  .dp_tx_en(dp_tx_en), .mii_col(mii_col), .mii_oe(mii_oe),
  .line_oe(line_tx_oe), .led_oe(led_oe)
);

// File: tb/sim_phy_ctl_top.sv
module sim_phy_ctl_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic [4:0]  s_addr;
  logic        s_an, s_f100, s_f10;
  logic        an_en, an_done, an_fd, an_kick, link_fd;
  logic [3:0]  txd;
  logic        tx_en, tx_er;
  logic [3:0]  dp_txd;
  logic        dp_tx_en, dp_tx_er;
  logic [3:0]  c_rxd;
  logic        c_rx_dv, c_rx_er, c_crs, c_col;
  logic        o_txc, o_rxc, o_dv, o_er, o_crs, o_col, o_oe, line_oe, led_oe;
  logic [3:0]  o_rxd;
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  phy_ctl_top u0 (
    .clk(clk), .rst_n(rst_n), .mgmt_wr_en(wr_en), .mgmt_wr_data(wr_data),
    .mgmt_rd_data(rd_data), .strap_phy_addr(s_addr), .strap_an_en(s_an),
    .strap_fd100(s_f100), .strap_fd10(s_f10), .an_enable(an_en),
    .an_done(an_done), .an_fd_result(an_fd), .an_kick(an_kick),
    .link_full_duplex(link_fd), .mii_txd(txd), .mii_tx_en(tx_en),
    .mii_tx_er(tx_er), .dp_txd(dp_txd), .dp_tx_en(dp_tx_en),
    .dp_tx_er(dp_tx_er), .core_tx_clk(1'b1), .core_rx_clk(1'b1),
    .core_rxd(c_rxd), .core_rx_dv(c_rx_dv), .core_rx_er(c_rx_er),
    .core_crs(c_crs), .core_col(c_col), .mii_tx_clk(o_txc),
    .mii_rx_clk(o_rxc), .mii_rxd(o_rxd), .mii_rx_dv(o_dv),
    .mii_rx_er(o_er), .mii_crs(o_crs), .mii_col(o_col), .mii_oe(o_oe),
    .line_tx_oe(line_oe), .led_oe(led_oe)
  );

  // [41]wr [40:25]wdata [24]an_en [23]done [22]tx_en [21]core_col
  // [20:5]exp_rd [4]exp_oe [3]exp_col [2]exp_kick [1]exp_dp_tx_en [0]exp_line_oe
  localparam int NV = 16;
  localparam logic [41:0] VEC [NV] = '{
    {1'b1,16'h0100,1'b0,1'b0,1'b0,1'b0,16'h0100,1'b1,1'b0,1'b0,1'b0,1'b1},
    {1'b1,16'h0180,1'b0,1'b0,1'b1,1'b0,16'h0180,1'b1,1'b1,1'b0,1'b1,1'b1},
    {1'b0,16'h0000,1'b0,1'b0,1'b0,1'b0,16'h0180,1'b1,1'b0,1'b0,1'b0,1'b1},
    {1'b1,16'h0480,1'b0,1'b0,1'b1,1'b0,16'h0480,1'b0,1'b0,1'b0,1'b0,1'b1},
    {1'b1,16'hFFFF,1'b0,1'b0,1'b0,1'b0,16'h0D80,1'b0,1'b0,1'b0,1'b0,1'b0},
    {1'b1,16'h0000,1'b0,1'b0,1'b1,1'b0,16'h0000,1'b1,1'b0,1'b0,1'b1,1'b1},
    {1'b1,16'h0200,1'b1,1'b0,1'b0,1'b0,16'h0200,1'b1,1'b0,1'b1,1'b0,1'b1},
    {1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0,16'h0200,1'b1,1'b0,1'b0,1'b0,1'b1},
    {1'b1,16'h0000,1'b1,1'b0,1'b0,1'b0,16'h0200,1'b1,1'b0,1'b0,1'b0,1'b1},
    {1'b0,16'h0000,1'b1,1'b1,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0,1'b1},
    {1'b1,16'h0800,1'b0,1'b0,1'b0,1'b0,16'h0800,1'b0,1'b0,1'b0,1'b0,1'b0},
    {1'b1,16'h0000,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0,1'b1},
    {1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,16'h0000,1'b1,1'b1,1'b0,1'b0,1'b1},
    {1'b1,16'h0200,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0,1'b1},
    {1'b1,16'h0200,1'b1,1'b1,1'b0,1'b0,16'h0200,1'b1,1'b0,1'b1,1'b0,1'b1},
    {1'b0,16'h0000,1'b1,1'b1,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0,1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_data = '0; an_done = 0; tx_en = 0; c_col = 0;
  endtask

  task automatic do_reset(input logic [4:0] a, input logic an, input logic f1, input logic f0);
    @(negedge clk);
    rst_n = 0; s_addr = a; s_an = an; s_f100 = f1; s_f10 = f0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle(); an_en = 0; an_fd = 0; txd = 4'h5; tx_er = 0;
    c_rxd = 4'hA; c_rx_dv = 1; c_rx_er = 0; c_crs = 1;
    s_addr = 0; s_an = 0; s_f100 = 0; s_f10 = 0;

    // R2: address zero, autoneg strap off, 100 FD strap on
    do_reset(5'd0, 1'b0, 1'b1, 1'b0);
    chk("R2 iso+dup", rd_data, 16'h0500);
    chk("R4 oe strap iso", {15'd0, o_oe}, 16'd0);
    // R3: strap changes after boot are ignored
    s_addr = 5'd3; s_an = 1; s_f100 = 0;
    repeat (4) @(negedge clk);
    chk("R3 straps late", rd_data, 16'h0500);
    // R2: 10 FD strap alone
    do_reset(5'd2, 1'b0, 1'b0, 1'b1);
    chk("R2 fd10", rd_data, 16'h0100);
    do_reset(5'd2, 1'b0, 1'b0, 1'b0);
    chk("R2 no fd", rd_data, 16'h0000);
    // R5: reset clears power-down
    wr(16'h0880);
    chk("R5 pd set", rd_data, 16'h0880);
    do_reset(5'd7, 1'b1, 1'b1, 1'b0);
    chk("R5 pd cleared by reset / R2 an strap", rd_data, 16'h0000);
    chk("R5 line oe", {14'd0, line_oe, led_oe}, 16'h0003);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_en = VEC[i][41]; wr_data = VEC[i][40:25]; an_en = VEC[i][24];
      an_done = VEC[i][23]; tx_en = VEC[i][22]; c_col = VEC[i][21];
      @(posedge clk); #2;
      chk("R1 readback", rd_data, VEC[i][20:5]);
      chk("R4 mii_oe", {15'd0, o_oe}, {15'd0, VEC[i][4]});
      chk("R9 col", {15'd0, o_col}, {15'd0, VEC[i][3]});
      chk("R6 kick", {15'd0, an_kick}, {15'd0, VEC[i][2]});
      chk("R4 dp_tx_en", {15'd0, dp_tx_en}, {15'd0, VEC[i][1]});
      chk("R5 line/led oe", {14'd0, line_oe, led_oe}, {14'd0, VEC[i][0], VEC[i][0]});
    end
    idle();

    // R7: pending request survives idle cycles until done
    an_en = 1;
    wr(16'h0200);
    repeat (3) @(negedge clk);
    chk("R7 held", rd_data, 16'h0200);
    an_done = 1; @(negedge clk); an_done = 0;
    chk("R7 cleared", rd_data, 16'h0000);

    // R8: duplex source selection
    an_en = 0; wr(16'h0000);
    chk("R8 manual hd", {15'd0, link_fd}, 16'd0);
    wr(16'h0100);
    chk("R8 manual fd", {15'd0, link_fd}, 16'd1);
    an_en = 1; an_fd = 0; @(negedge clk);
    chk("R8 an hd", {15'd0, link_fd}, 16'd0);
    an_fd = 1; wr(16'h0000); @(negedge clk);
    chk("R8 an fd", {15'd0, link_fd}, 16'd1);
    an_en = 0;

    // R4: isolation of receive path and transmit inputs, management live
    tx_en = 1; tx_er = 1;
    wr(16'h0400);
    chk("R4 rxd iso", {12'd0, o_rxd}, 16'd0);
    chk("R4 status iso", {12'd0, o_dv, o_crs, o_txc, o_rxc}, 16'd0);
    chk("R4 tx iso", {10'd0, dp_txd, dp_tx_en, dp_tx_er}, 16'd0);
    chk("R4 mgmt live", rd_data, 16'h0400);
    wr(16'h0000);
    chk("R4 rxd pass", {12'd0, o_rxd}, 16'h000A);
    chk("R4 tx pass", {10'd0, dp_txd, dp_tx_en, dp_tx_er}, 16'h0017);
    idle(); tx_er = 0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule